// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This controller gathers up to 32 interrupt inputs and presents them to a processor on two separate request lines, a normal line and a fast line. Each input first passes a conditioning stage that is shared by both banks. That stage can invert the input and can hold a brief pulse until software acknowledges it. Each bank then applies its own enable mask and its own priority threshold, and drives its request line while any surviving source is pending.

Software reaches the block through a plain 32-bit register bus. Each bank offers a pending status word and a word that names the source to service next. The lowest priority value wins, and on a tie the lowest source number wins. Each bank also has a read-to-acknowledge word, separate set and clear addresses for its enable mask, and a 4-bit threshold. The polarity selects, latch selects and per-source priority words are shared by both banks. A typical handler reads the next-source word and services that source, then reads again until the status word is zero.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, both enable masks are 0, all latches are clear, every priority is 0, both thresholds read 0xF, the polarity word reads all ones, the latch-select word reads 0, and both request lines are low.
- R2: In a bank, writing a word to offset 0x08 sets those enable bits, writing a word to offset 0x0C clears those enable bits, and reading offset 0x08 returns the mask.
- R3: Offset 0x04 of a bank returns the conditioned inputs before the mask and threshold are applied. A polarity bit of 1 (word at 0x200) passes the input unchanged, and a bit of 0 inverts it.
- R4: A source whose bit in the latch-select word (0x204) is 1 stays pending after its input falls, until an acknowledge clears it. A source whose bit is 0 follows its conditioned input.
- R5: A bank's status word (offset 0x00) is the conditioned input ANDed with the enable mask and with eligibility, where eligibility means the source's priority is less than or equal to the bank's threshold (offset 0x2C, 4 bits). The bank's request line is high exactly while that word is nonzero.
- R6: Offset 0x20 returns the number of the status source with the smallest priority value. Ties go to the lowest number. It returns 32 when the status word is zero.
- R7: A read of offset 0x28 returns the bank's status word and clears the latches of exactly those sources. The clear does not touch the other bank's pending latches. A source whose input is still asserted stays pending, and level sources are unaffected.
- R8: The normal bank occupies offsets 0x000 to 0x0FF and drives `irq_req`. The fast bank occupies offsets 0x100 to 0x1FF and drives `fiq_req`. The masks and thresholds of the two banks are independent.
- R9: Source n's priority is the word at 0x300 + 4n. Only bits 3:0 are stored, and the word reads back zero-extended.
- R10: Read data appears on `bus_rd_data` the cycle after `bus_rd_en` is high, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_in | input | 32 | Interrupt inputs, already synchronous |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; a read of the acknowledge offset has a side effect |
| bus_rd_data | output | 32 | Registered read data |
| irq_req | output | 1 | Normal bank request |
| fiq_req | output | 1 | Fast bank request |

## Verification
The bench checks that a tie in priority goes to the lower source number. A picker that scans in the wrong direction or compares with "less or equal" would name the higher source. It checks that a source just above the threshold is withheld and that one exactly at it is accepted, which catches an off-by-one in the eligibility compare. It checks that an acknowledge in the fast bank leaves the normal bank's latched source pending and that a latch whose input is still high survives its acknowledge. A shared or unconditional clear would drop interrupts there. Inverted polarity and a pulse on a non-latched source show whether the conditioning stage confuses the two selects.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned BUS_ADDR_W = 12;
    localparam int unsigned BUS_DATA_W = 32;

    // region codes held in bus_addr[11:8]
    localparam logic [3:0] RGN_NORM   = 4'h0;
    localparam logic [3:0] RGN_FAST   = 4'h1;
    localparam logic [3:0] RGN_COND   = 4'h2;
    localparam logic [3:0] RGN_PRIO   = 4'h3;

    // offsets inside a bank region
    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_RAW    = 8'h04;
    localparam logic [7:0] OFS_EN_SET = 8'h08;
    localparam logic [7:0] OFS_EN_CLR = 8'h0C;
    localparam logic [7:0] OFS_NEXT   = 8'h20;
    localparam logic [7:0] OFS_ACK    = 8'h28;
    localparam logic [7:0] OFS_THR    = 8'h2C;

    // offsets inside the conditioning region
    localparam logic [7:0] OFS_POL    = 8'h00;
    localparam logic [7:0] OFS_LATCH  = 8'h04;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol_sel,
    input  logic [NUM_SRC-1:0] latch_sel,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] cond,
    output logic [NUM_SRC-1:0] latch_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] hold;
    } cond_state_t;

    cond_state_t st_d, st_q;
    logic [NUM_SRC-1:0] lvl;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pol
        assign lvl[i] = pol_sel[i] ? src_in[i] : ~src_in[i];
    end

    always_comb begin
        st_d = st_q;
        // an asserted input wins over a clear in the same cycle
        st_d.hold = latch_sel & (lvl | (st_q.hold & ~clr));
        cond      = (latch_sel & st_q.hold) | (~latch_sel & lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.hold;
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]                next_id
);
    logic              found;
    logic [PRIO_W-1:0] best;

    always_comb begin
        found   = 1'b0;
        best    = '1;
        next_id = ID_W'(NUM_SRC);
        // strict compare keeps the lowest index on a tie
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!found || prio[i] < best)) begin
                found   = 1'b1;
                best    = prio[i];
                next_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             cond,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic                           en_set_we,
    input  logic                           en_clr_we,
    input  logic                           thr_we,
    input  logic [NUM_SRC-1:0]             wr_mask,
    input  logic [PRIO_W-1:0]              wr_thr,
    output logic [NUM_SRC-1:0]             enable,
    output logic [PRIO_W-1:0]              thr,
    output logic [NUM_SRC-1:0]             status,
    output logic [ID_W-1:0]                next_id,
    output logic                           req
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [PRIO_W-1:0]  thr;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NUM_SRC-1:0] elig;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = (prio[i] <= st_q.thr);
    end

    always_comb begin
        st_d = st_q;
        if (en_set_we) st_d.en  = st_q.en | wr_mask;
        if (en_clr_we) st_d.en  = st_q.en & ~wr_mask;
        if (thr_we)    st_d.thr = wr_thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= '0;
            st_q.thr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.en;
    assign thr    = st_q.thr;
    assign status = cond & st_q.en & elig;
    assign req    = |status;

    intc_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
        .pend    (status),
        .prio    (prio),
        .next_id (next_id)
    );
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_in,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr_en,
    input  logic [BUS_DATA_W-1:0] bus_wr_data,
    input  logic                  bus_rd_en,
    output logic [BUS_DATA_W-1:0] bus_rd_data,
    output logic                  irq_req,
    output logic                  fiq_req
);
    localparam int unsigned NBANK = 2;
    localparam int unsigned ID_W  = $clog2(NUM_SRC + 1);
    localparam int unsigned SRC_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0]             pol;
        logic [NUM_SRC-1:0]             latch;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [BUS_DATA_W-1:0]          rdata;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic [3:0]                       region;
    logic [7:0]                       ofs;
    logic                             aligned;
    logic                             prio_ok;
    logic [SRC_W-1:0]                 prio_idx;
    logic [NBANK-1:0]                 bank_hit;
    logic [NBANK-1:0]                 en_set_we, en_clr_we, thr_we, ack_hit;
    logic [NBANK-1:0][NUM_SRC-1:0]    bank_en, bank_status;
    logic [NBANK-1:0][PRIO_W-1:0]     bank_thr;
    logic [NBANK-1:0][ID_W-1:0]       bank_next;
    logic [NBANK-1:0]                 bank_req;
    logic [NUM_SRC-1:0]               cond, latch_q, ack_clr;

    assign region   = bus_addr[11:8];
    assign ofs      = bus_addr[7:0];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign prio_idx = bus_addr[2 +: SRC_W];
    assign prio_ok  = aligned && (region == RGN_PRIO) && ({2'b00, bus_addr[7:2]} < 8'(NUM_SRC));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_hit[b]  = aligned && (region == 4'(b));
        assign en_set_we[b] = bus_wr_en && bank_hit[b] && (ofs == OFS_EN_SET);
        assign en_clr_we[b] = bus_wr_en && bank_hit[b] && (ofs == OFS_EN_CLR);
        assign thr_we[b]    = bus_wr_en && bank_hit[b] && (ofs == OFS_THR);
        assign ack_hit[b]   = bus_rd_en && bank_hit[b] && (ofs == OFS_ACK);

        intc_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond      (cond),
            .prio      (cfg_q.prio),
            .en_set_we (en_set_we[b]),
            .en_clr_we (en_clr_we[b]),
            .thr_we    (thr_we[b]),
            .wr_mask   (bus_wr_data[NUM_SRC-1:0]),
            .wr_thr    (bus_wr_data[PRIO_W-1:0]),
            .enable    (bank_en[b]),
            .thr       (bank_thr[b]),
            .status    (bank_status[b]),
            .next_id   (bank_next[b]),
            .req       (bank_req[b])
        );
    end

    always_comb begin
        ack_clr = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (ack_hit[b]) ack_clr = ack_clr | bank_status[b];
        end
    end

    intc_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .pol_sel   (cfg_q.pol),
        .latch_sel (cfg_q.latch),
        .clr       (ack_clr),
        .cond      (cond),
        .latch_q   (latch_q)
    );

    always_comb begin
        logic                  sel;
        logic [BUS_DATA_W-1:0] mux;
        cfg_d = cfg_q;
        sel   = region[0];
        mux   = '0;

        if (bus_wr_en && aligned && region == RGN_COND) begin
            if (ofs == OFS_POL)   cfg_d.pol   = bus_wr_data[NUM_SRC-1:0];
            if (ofs == OFS_LATCH) cfg_d.latch = bus_wr_data[NUM_SRC-1:0];
        end
        if (bus_wr_en && prio_ok) begin
            cfg_d.prio[prio_idx] = bus_wr_data[PRIO_W-1:0];
        end

        if (aligned) begin
            unique case (region)
                RGN_NORM, RGN_FAST: begin
                    unique case (ofs)
                        OFS_STATUS, OFS_ACK: mux = BUS_DATA_W'(bank_status[sel]);
                        OFS_RAW:             mux = BUS_DATA_W'(cond);
                        OFS_EN_SET:          mux = BUS_DATA_W'(bank_en[sel]);
                        OFS_NEXT:            mux = BUS_DATA_W'(bank_next[sel]);
                        OFS_THR:             mux = BUS_DATA_W'(bank_thr[sel]);
                        default:             mux = '0;
                    endcase
                end
                RGN_COND: begin
                    if (ofs == OFS_POL)        mux = BUS_DATA_W'(cfg_q.pol);
                    else if (ofs == OFS_LATCH) mux = BUS_DATA_W'(cfg_q.latch);
                end
                RGN_PRIO: begin
                    if (prio_ok) mux = BUS_DATA_W'(cfg_q.prio[prio_idx]);
                end
                default: mux = '0;
            endcase
        end
        if (bus_rd_en) cfg_d.rdata = mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.pol   <= '1;
            cfg_q.latch <= '0;
            cfg_q.prio  <= '0;
            cfg_q.rdata <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign bus_rd_data = cfg_q.rdata;
    assign irq_req     = bank_req[0];
    assign fiq_req     = bank_req[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [BUS_ADDR_W-1:0]     bus_addr,
    input logic                      bus_wr_en,
    input logic [BUS_DATA_W-1:0]     bus_wr_data,
    input logic                      bus_rd_en,
    input logic [BUS_DATA_W-1:0]     bus_rd_data,
    input logic                      irq_req,
    input logic                      fiq_req,
    input logic [1:0][NUM_SRC-1:0]   bank_en,
    input logic [NUM_SRC-1:0]        latch_q,
    input logic [NUM_SRC-1:0]        latch_sel,
    input logic [1:0]                ack_hit
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_req && !fiq_req));

    assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 12'h00C) |=> ((bank_en[0] & $past(bus_wr_data[NUM_SRC-1:0])) == '0));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_hit == 2'b00) && $stable(latch_sel)) |=> (($past(latch_q) & ~latch_q) == '0));

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (bank_en[0] != '0));

    assert_fiq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |-> (bank_en[1] != '0));

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rd_data));
endmodule

bind intc_dual_bank intc_checker #(.NUM_SRC(NUM_SRC)) u_intc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .irq_req     (irq_req),
    .fiq_req     (fiq_req),
    .bank_en     (bank_en),
    .latch_q     (latch_q),
    .latch_sel   (cfg_q.latch),
    .ack_hit     (ack_hit)
);

// File: tb/test_intc_dual_bank.sv
module test_intc_dual_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic        irq_req, fiq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    intc_dual_bank i_intc_dual_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
        .bus_rd_data(bus_rd_data), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    // table: src_in, normal-bank enable, expected status, expected next source
    localparam logic [127:0] VEC [6] = '{
        {32'h0000_0088, 32'hFFFF_FFFF, 32'h0000_0088, 32'd7 },
        {32'h0010_0008, 32'hFFFF_FFFF, 32'h0010_0008, 32'd3 },
        {32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0003, 32'd0 },
        {32'h0000_0006, 32'hFFFF_FFFF, 32'h0000_0006, 32'd1 },
        {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'd32},
        {32'h0010_0000, 32'hFFFF_FFFF, 32'h0010_0000, 32'd20}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // R10: data is taken one cycle after the strobe
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_req", {31'b0, irq_req}, 32'd0);
        check("R1 fiq_req", {31'b0, fiq_req}, 32'd0);
        rd_chk("R1 norm thr", 12'h02C, 32'hF);
        rd_chk("R1 fast thr", 12'h12C, 32'hF);
        rd_chk("R1 norm en", 12'h008, 32'h0);
        rd_chk("R1 pol", 12'h200, 32'hFFFF_FFFF);
        rd_chk("R1 latch sel", 12'h204, 32'h0);
        rd_chk("R1 prio5", 12'h314, 32'h0);
        rd_chk("R10 raw idle", 12'h004, 32'h0);

        // R9 priority words
        wr(12'h30C, 32'd2);
        wr(12'h31C, 32'd1);
        wr(12'h350, 32'd5);
        wr(12'h354, 32'hFFFF_FFF7);
        rd_chk("R9 prio20", 12'h350, 32'd5);
        rd_chk("R9 prio21 trunc", 12'h354, 32'd7);

        // R5/R6 table walk
        for (int k = 0; k < 6; k++) begin
            wr(12'h00C, 32'hFFFF_FFFF);
            wr(12'h008, VEC[k][95:64]);
            src_in = VEC[k][127:96];
            @(negedge clk);
            rd_chk("R5 status", 12'h000, VEC[k][63:32]);
            rd_chk("R6 next", 12'h020, VEC[k][31:0]);
            check("R5 irq_req", {31'b0, irq_req}, {31'b0, |VEC[k][63:32]});
        end
        check("R8 fiq idle", {31'b0, fiq_req}, 32'd0);

        // R2 set / clear
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0000_000F);
        wr(12'h00C, 32'h0000_0005);
        rd_chk("R2 enable", 12'h008, 32'h0000_000A);

        // R5 threshold boundary (source 20 has priority 5)
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0010_0000);
        src_in = 32'h0010_0000;
        wr(12'h02C, 32'd4);
        rd_chk("R5 below thr", 12'h000, 32'h0);
        check("R5 req below thr", {31'b0, irq_req}, 32'd0);
        rd_chk("R3 raw unmasked", 12'h004, 32'h0010_0000);
        wr(12'h02C, 32'd5);
        rd_chk("R5 at thr", 12'h000, 32'h0010_0000);
        check("R5 req at thr", {31'b0, irq_req}, 32'd1);

        // R8 fast bank independent
        wr(12'h108, 32'h0010_0000);
        rd_chk("R8 fast status", 12'h100, 32'h0010_0000);
        wr(12'h00C, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R8 irq off", {31'b0, irq_req}, 32'd0);
        check("R8 fiq on", {31'b0, fiq_req}, 32'd1);
        wr(12'h10C, 32'hFFFF_FFFF);
        src_in = '0;

        // R3 polarity
        wr(12'h200, ~32'h0000_0200);
        rd_chk("R3 inverted low", 12'h004, 32'h0000_0200);
        src_in = 32'h0000_0200;
        rd_chk("R3 inverted high", 12'h004, 32'h0);
        src_in = '0;
        wr(12'h200, 32'hFFFF_FFFF);

        // R4 latched vs level (bits 4,5 latched; bit 6 level)
        wr(12'h204, 32'h0000_0030);
        @(negedge clk); src_in = 32'h0000_0050;
        @(negedge clk); src_in = '0;
        rd_chk("R4 pulse kept", 12'h004, 32'h0000_0010);
        @(negedge clk); src_in = 32'h0000_0020;
        @(negedge clk); src_in = '0;
        rd_chk("R4 two latched", 12'h004, 32'h0000_0030);

        // R7 per-bank acknowledge
        wr(12'h008, 32'h0000_0010);
        wr(12'h108, 32'h0000_0020);
        rd_chk("R7 fast ack", 12'h128, 32'h0000_0020);
        rd_chk("R7 other bank kept", 12'h004, 32'h0000_0010);
        check("R7 irq still", {31'b0, irq_req}, 32'd1);
        check("R7 fiq dropped", {31'b0, fiq_req}, 32'd0);
        rd_chk("R7 norm ack", 12'h028, 32'h0000_0010);
        rd_chk("R7 all clear", 12'h004, 32'h0);

        // R7 ack with inputs still asserted
        src_in = 32'h0000_0050;
        wr(12'h008, 32'h0000_0040);
        rd_chk("R7 ack busy", 12'h028, 32'h0000_0050);
        rd_chk("R7 held sources", 12'h004, 32'h0000_0050);
        check("R7 req held", {31'b0, irq_req}, 32'd1);
        src_in = '0;
        @(negedge clk);
        rd_chk("R4 latch after drop", 12'h004, 32'h0000_0010);

        finish_run();
    end
endmodule